// File: doc/BRIEF.md
# Multi-Output Programmable Clock Divider Controller

This block takes one fast source clock and derives four system clock waveforms from it. Every output is built in the source clock domain as two signals: a registered level and a one-cycle rising-edge strobe, the strobe being a qualified enable for logic that runs on the source clock. A shared post-divider comes first and sets the base rate that all four outputs count in. Outputs 1 and 2 run at that base rate and cannot be reprogrammed. Outputs 3 and 4 each have a divide ratio that software can write, and each can be switched off on its own.

Software uses a small write port with four addresses. Ratio values written to the post-divider and to outputs 3 and 4 wait in a pending stage. A commit strobe moves them into the live dividers, and each divider takes its new value only at the boundary of its own period. A gate bit takes effect at the next period boundary without a commit. No output therefore ever shows a shortened high or low phase.

Top module: `sysclk_div_ctrl`

## Requirements
- R1: Reset holds every level and strobe low. After reset, output 3 divides by 3 (period 3, high for 2 cycles) and output 4 divides by 5 (period 5, high for 3 cycles). The post-divider starts disabled and all gates start on.
- R2: Outputs 1 and 2 (index 0 and 1) strobe once per post-divided cycle and hold their level high. Writes to the output 3 and 4 registers never change them.
- R3: Address 1 sets output 3 (index 2). Bits [4:0] hold a ratio field N that selects divide-by-(N+1), so the range is /1 to /32.
- R4: Address 2 sets output 4 (index 3) with the same field layout and the same divide-by-(N+1) rule as output 3.
- R5: Ratio values written to addresses 0, 1 and 2 have no effect until a write to address 3 with bit 0 set commits them.
- R6: A committed ratio takes effect at the next rising edge of that output. The first full period after that edge already uses the new ratio.
- R7: With a post-divided period P, divide-by-N gives a period of N*P source cycles and a high time of ceil(N/2)*P cycles. Even ratios therefore give a 50% duty cycle, and odd ratios give one extra high base cycle.
- R8: Bit 5 at address 1 or 2 is the run bit of that output. A 0 holds the output low with no strobes, and a 1 runs it. A change takes effect at the next period boundary, so when an output comes back on, its first period is full length.
- R9: Address 0 sets the post-divider. Bits [3:0] hold a ratio field M and bit 4 is the enable, both committed by the R5 strobe. When enabled, P = M+1. When disabled, P = 1 and the source clock passes through undivided.
- R10: Divide-by-1 makes an output strobe on every post-divided cycle with its level held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 post-divider, 1 output 3, 2 output 4, 3 commit) |
| wr_data_i | input | 6 | Write data |
| clk_lvl_o | output | 4 | Divided clock levels, index 0 is output 1 |
| clk_tick_o | output | 4 | One-cycle strobe at each rising edge of the matching level |

## Verification
The hardest case to reach is a commit that lands partway through a period while the post-divider is also changing. In that case the old period must finish intact, and the next period must show both the new ratio and the new base rate. The stimulus draws random pairs of ratios and random post-divider settings, commits them at arbitrary phases and measures the very first period after the commit. Directed cases add the /1 and /32 limits, a write with no commit, and gating an output off and back on.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;
  localparam logic [1:0] ADDR_POSTDIV = 2'd0;
  localparam logic [1:0] ADDR_OUT3    = 2'd1;
  localparam logic [1:0] ADDR_OUT4    = 2'd2;
  localparam logic [1:0] ADDR_COMMIT  = 2'd3;
  localparam int unsigned NUM_OUTS    = 4;
  localparam int unsigned NUM_FIXED   = 2;
endpackage

// File: rtl/sysclk_div_regs.sv
module sysclk_div_regs
  import sysclk_div_pkg::*;
#(
  parameter int unsigned RW   = 5,
  parameter int unsigned PW   = 4,
  parameter int unsigned DEF3 = 2,
  parameter int unsigned DEF4 = 4,
  localparam int unsigned DW  = RW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [RW-1:0] cm_r3_o,
  output logic [RW-1:0] cm_r4_o,
  output logic          run3_o,
  output logic          run4_o,
  output logic [PW-1:0] cm_pr_o,
  output logic          cm_pe_o
);
  logic [RW-1:0] pd3_q, pd3_d, pd4_q, pd4_d, cm3_q, cm3_d, cm4_q, cm4_d;
  logic [PW-1:0] ppr_q, ppr_d, cpr_q, cpr_d;
  logic          ppe_q, ppe_d, cpe_q, cpe_d;
  logic          g3_q, g3_d, g4_q, g4_d;
  logic          commit;

  assign commit = wr_en_i && (wr_addr_i == ADDR_COMMIT) && wr_data_i[0];

  always_comb begin
    pd3_d = pd3_q;
    pd4_d = pd4_q;
    ppr_d = ppr_q;
    ppe_d = ppe_q;
    g3_d  = g3_q;
    g4_d  = g4_q;
    cm3_d = cm3_q;
    cm4_d = cm4_q;
    cpr_d = cpr_q;
    cpe_d = cpe_q;
    if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_POSTDIV: begin
          ppr_d = wr_data_i[PW-1:0];
          ppe_d = wr_data_i[PW];
        end
        ADDR_OUT3: begin
          pd3_d = wr_data_i[RW-1:0];
          g3_d  = wr_data_i[RW];
        end
        ADDR_OUT4: begin
          pd4_d = wr_data_i[RW-1:0];
          g4_d  = wr_data_i[RW];
        end
        default: ;
      endcase
    end
    if (commit) begin
      cm3_d = pd3_q;
      cm4_d = pd4_q;
      cpr_d = ppr_q;
      cpe_d = ppe_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd3_q <= RW'(DEF3);
      pd4_q <= RW'(DEF4);
      cm3_q <= RW'(DEF3);
      cm4_q <= RW'(DEF4);
      ppr_q <= '0;
      cpr_q <= '0;
      ppe_q <= 1'b0;
      cpe_q <= 1'b0;
      g3_q  <= 1'b1;
      g4_q  <= 1'b1;
    end else begin
      pd3_q <= pd3_d;
      pd4_q <= pd4_d;
      cm3_q <= cm3_d;
      cm4_q <= cm4_d;
      ppr_q <= ppr_d;
      cpr_q <= cpr_d;
      ppe_q <= ppe_d;
      cpe_q <= cpe_d;
      g3_q  <= g3_d;
      g4_q  <= g4_d;
    end
  end

  assign cm_r3_o = cm3_q;
  assign cm_r4_o = cm4_q;
  assign run3_o  = g3_q;
  assign run4_o  = g4_q;
  assign cm_pr_o = cpr_q;
  assign cm_pe_o = cpe_q;

  // R5: committed values move only on a commit strobe
  p_commit_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> ($stable(cm3_q) && $stable(cm4_q) && $stable(cpr_q) && $stable(cpe_q)));
endmodule

// File: rtl/sysclk_div_post.sv
module sysclk_div_post #(
  parameter int unsigned PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] ratio_i,
  input  logic          en_i,
  output logic          adv_o
);
  logic [PW-1:0] cnt_q, cnt_d, rat_q, rat_d;
  logic          en_q, en_d;
  logic          adv;

  assign adv = !en_q || (cnt_q == rat_q);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    rat_d = rat_q;
    en_d  = en_q;
    if (adv) begin
      cnt_d = '0;
      rat_d = ratio_i;
      en_d  = en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rat_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rat_q <= rat_d;
      en_q  <= en_d;
    end
  end

  assign adv_o = adv;

  // R9: an enabled ratio above zero never advances on two cycles in a row
  p_spacing_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv ##1 (en_q && rat_q != '0) |-> !adv);
endmodule

// File: rtl/sysclk_div_chan.sv
module sysclk_div_chan #(
  parameter int unsigned RW  = 5,
  parameter int unsigned DEF = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [RW-1:0] ratio_i,
  input  logic          run_i,
  output logic          lvl_o,
  output logic          tick_o
);
  logic [RW-1:0] ph_q, ph_d, act_q, act_d;
  logic          run_q, run_d, lvl_q, lvl_d, tick_q, tick_d;
  logic [RW:0]   hi_len;
  logic          wrap;

  assign wrap = (ph_q == act_q);

  always_comb begin
    ph_d   = ph_q;
    act_d  = act_q;
    run_d  = run_q;
    lvl_d  = lvl_q;
    tick_d = 1'b0;
    if (adv_i) begin
      if (wrap) begin
        ph_d  = '0;
        act_d = ratio_i;
        run_d = run_i;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
    hi_len = ({1'b0, act_d} + (RW+1)'(2)) >> 1;
    if (adv_i) begin
      lvl_d  = run_d && ({1'b0, ph_d} < hi_len);
      tick_d = run_d && wrap;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      act_q  <= RW'(DEF);
      run_q  <= 1'b1;
      lvl_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      act_q  <= act_d;
      run_q  <= run_d;
      lvl_q  <= lvl_d;
      tick_q <= tick_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign tick_o = tick_q;

  // R6: the live ratio changes only at a period boundary
  p_ratio_at_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adv_i && wrap) |=> $stable(act_q));
  // R8: the run state changes only at a period boundary
  p_gate_at_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adv_i && wrap) |=> $stable(run_q));
  // R7: the level holds between post-divided cycles
  p_hold_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(lvl_q));
endmodule

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl
  import sysclk_div_pkg::*;
#(
  parameter int unsigned RW   = 5,
  parameter int unsigned PW   = 4,
  parameter int unsigned DEF3 = 2,
  parameter int unsigned DEF4 = 4,
  localparam int unsigned DW  = RW + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [NUM_OUTS-1:0] clk_lvl_o,
  output logic [NUM_OUTS-1:0] clk_tick_o
);
  logic [1:0]    rs_q;
  logic          rst_n;
  logic [RW-1:0] cm_r3, cm_r4;
  logic          run3, run4, cm_pe, adv;
  logic [PW-1:0] cm_pr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  sysclk_div_regs #(.RW(RW), .PW(PW), .DEF3(DEF3), .DEF4(DEF4)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cm_r3_o(cm_r3), .cm_r4_o(cm_r4), .run3_o(run3),
    .run4_o(run4), .cm_pr_o(cm_pr), .cm_pe_o(cm_pe)
  );

  sysclk_div_post #(.PW(PW)) u_post (
    .clk_i(clk_i), .rst_ni(rst_n), .ratio_i(cm_pr), .en_i(cm_pe), .adv_o(adv)
  );

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_out
    if (g < NUM_FIXED) begin : g_fixed
      sysclk_div_chan #(.RW(RW), .DEF(0)) u_chan (
        .clk_i(clk_i), .rst_ni(rst_n), .adv_i(adv), .ratio_i('0), .run_i(1'b1),
        .lvl_o(clk_lvl_o[g]), .tick_o(clk_tick_o[g])
      );
    end else begin : g_prog
      localparam int unsigned DEFG = (g == NUM_FIXED) ? DEF3 : DEF4;
      sysclk_div_chan #(.RW(RW), .DEF(DEFG)) u_chan (
        .clk_i(clk_i), .rst_ni(rst_n), .adv_i(adv),
        .ratio_i((g == NUM_FIXED) ? cm_r3 : cm_r4),
        .run_i((g == NUM_FIXED) ? run3 : run4),
        .lvl_o(clk_lvl_o[g]), .tick_o(clk_tick_o[g])
      );
    end
  end

  // R2: the fixed outputs keep their level high once running
  p_fixed_high_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    clk_tick_o[0] |=> clk_lvl_o[0] && clk_lvl_o[1]);
endmodule

// File: tb/tb_sysclk_div_ctrl.sv
module tb_sysclk_div_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic [3:0] lvl, tick;
  int errors = 0;
  int checks = 0;
  int r3 = 2, r4 = 4, pr = 0, pe = 0;

  sysclk_div_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .clk_lvl_o(lvl), .clk_tick_o(tick)
  );

  always #5 clk = ~clk;

  function automatic int base_p();
    return (pe != 0) ? pr + 1 : 1;
  endfunction
  function automatic int exp_per(int r);
    return (r + 1) * base_p();
  endfunction
  function automatic int exp_hi(int r);
    return ((r + 2) / 2) * base_p();
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic commit();
    wr(2'd3, 6'd1);
  endtask

  task automatic measure(int idx, output int per, output int hi);
    int to = 0;
    per = -1; hi = -1;
    do begin
      @(negedge clk);
      to++;
    end while (!tick[idx] && to < 3000);
    if (to >= 3000) return;
    per = 0; hi = 0;
    do begin
      per++;
      if (lvl[idx]) hi++;
      @(negedge clk);
    end while (!tick[idx] && per < 3000);
  endtask

  task automatic expect_out(string req, int idx, int r);
    int per, hi;
    measure(idx, per, hi);
    chk({req, " period"}, per, exp_per(r));
    chk({req, " high"}, hi, exp_hi(r));
  endtask

  task automatic activity(int idx, int n, output int ticks, output int highs);
    ticks = 0; highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick[idx]) ticks++;
      if (lvl[idx]) highs++;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t, h;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset level", int'(lvl), 0);
    chk("R1 reset tick", int'(tick), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    expect_out("R1 out3 default", 2, 2);
    expect_out("R1 out4 default", 3, 4);
    expect_out("R2 out1", 0, 0);
    expect_out("R2 out2", 1, 0);

    // R5: pending write without commit keeps the old ratio
    wr(2'd1, {1'b1, 5'd7});
    repeat (4) @(negedge clk);
    expect_out("R5 no commit", 2, r3);
    commit(); r3 = 7;
    expect_out("R6 first period new", 2, r3);
    expect_out("R7 even /8", 2, r3);
    expect_out("R2 unaffected", 0, 0);

    wr(2'd1, {1'b1, 5'd31}); commit(); r3 = 31;
    expect_out("R3 max /32", 2, r3);
    wr(2'd1, {1'b1, 5'd0}); commit(); r3 = 0;
    expect_out("R10 out3 /1", 2, r3);
    wr(2'd1, {1'b1, 5'd2}); commit(); r3 = 2;
    expect_out("R7 odd /3", 2, r3);
    wr(2'd2, {1'b1, 5'd8}); commit(); r4 = 8;
    expect_out("R4 out4 /9", 3, r4);

    // R9: post-divider enabled and bypassed
    wr(2'd0, 6'h13); commit(); pr = 3; pe = 1;
    expect_out("R9 out1 pd4", 0, 0);
    expect_out("R9 out3 pd4", 2, r3);
    expect_out("R9 out4 pd4", 3, r4);
    wr(2'd0, 6'h05); commit(); pr = 5; pe = 0;
    expect_out("R9 bypass out1", 0, 0);
    expect_out("R9 bypass out3", 2, r3);

    // R8: gate output 3 off, output 4 keeps running
    wr(2'd1, {1'b0, 5'd2});
    repeat (10) @(negedge clk);
    activity(2, 200, t, h);
    chk("R8 off ticks", t, 0);
    chk("R8 off level", h, 0);
    expect_out("R8 out4 still runs", 3, r4);
    wr(2'd1, {1'b1, 5'd2});
    expect_out("R8 re-enable full", 2, r3);
    wr(2'd2, {1'b0, 5'd8});
    repeat (20) @(negedge clk);
    activity(3, 100, t, h);
    chk("R8 out4 off ticks", t, 0);
    chk("R8 out4 off level", h, 0);
    wr(2'd2, {1'b1, 5'd8});
    expect_out("R8 out4 re-enable", 3, r4);

    // random ratio and post-divider changes
    for (int i = 0; i < 20; i++) begin
      int nr3, nr4, npr, npe, wait_n;
      nr3 = int'($urandom % 32);
      nr4 = int'($urandom % 32);
      npr = int'($urandom % 16);
      npe = int'($urandom % 2);
      wait_n = int'($urandom % 40);
      wr(2'd1, {1'b1, 5'(nr3)});
      wr(2'd2, {1'b1, 5'(nr4)});
      wr(2'd0, {1'b0, 1'(npe), 4'(npr)});
      repeat (wait_n) @(negedge clk);
      commit();
      r3 = nr3; r4 = nr4; pr = npr; pe = npe;
      expect_out("R6 random out3", 2, r3);
      expect_out("R3 random out3", 2, r3);
      expect_out("R4 random out4", 3, r4);
      expect_out("R9 random out1", 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule